// File: doc/BRIEF.md
# Thread Interrupt Context Pull Unit

This block keeps the interrupt context of one hardware thread as four privilege rings, ordered from least to most privileged: user (ring 0), OS (ring 1), pool (ring 2) and physical/hypervisor (ring 3). Each ring owns a 32-bit CAM word. The word records whether the ring holds a live virtual processor, whether hardware owns that context, and which virtual processor it is.

Software reaches the block through single-beat load/store accesses. Each access carries a page privilege level and a 12-bit offset. Plain accesses on the hypervisor page read or write a ring's CAM word. Special offsets "pull" a context. A pull hands back the CAM word as it was before the pull. It invalidates the target ring and every ring beneath it, and drops the interrupt output of each affected ring that has one. When the save/restore configuration input is set and the pulled context is hardware-owned, the block first issues a save request over a valid/ready handshake. The pull finishes in the cycle that request is taken. Writing the saved context to memory happens outside this block.

Top module: `ctxpull_unit`

## Requirements
- R1: In a CAM word, bit 31 is the valid flag and bit 30 the hardware-owned flag. Bits 27:24 hold the VP block and bits 23:0 the VP index. On the page level 3 (hypervisor) the word of ring r sits at offset r*0x10+0x8: a load returns it and a store replaces it. After reset every word is zero.
- R2: A load at offset 0x818 from page level 1, 2 or 3 pulls ring 1 and returns ring 1's CAM word as it was before the pull.
- R3: A pull of ring t clears bit 31 of rings 0..t. It leaves bits 30:0 of those words, and all of rings above t, unchanged.
- R4: A pull of ring t drives the interrupt outputs of rings 1..t low. Outputs of rings above t keep their value. Ring 0 has no output.
- R5: A save request (save_valid_o) is raised only when cfg_save_en_i is set and bit 30 of the pulled ring's word is set. It carries the ring number, the VP block and the VP index. It holds valid and its fields stable until save_ready_i is seen.
- R6: While a save request is pending, req_ready_o is low. The invalidation and the interrupt drop do not happen until the cycle the request is accepted. The response follows on the next cycle.
- R7: A pull of a ring whose valid bit is already clear is carried out in full, and sw_err_o pulses together with its response.
- R8: A store at 0xC38 from page level 3 pulls ring 3. A store at 0xC18 from page level 1, 2 or 3 pulls ring 1. A store pull responds with data zero.
- R9: Any access that matches no operation (including 0xC38 from a page below level 3, and CAM stores from a page below level 3) changes no state. It responds with data zero and a one-cycle rsp_err_o.
- R10: Every accepted access gets rsp_valid_o in the following cycle. For a pull with no save, the invalidation and the interrupt drop are visible in that same cycle.
- R11: A pulse on irq_raise_i[r] sets the output of ring r. When a raise and a pull that lowers the same ring fall in one cycle, the output ends low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_save_en_i | input | 1 | Global save/restore enable |
| req_valid_i | input | 1 | Access request valid |
| req_ready_o | output | 1 | Block can accept an access |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_page_i | input | 2 | Page privilege level (0 user .. 3 hypervisor) |
| req_addr_i | input | 12 | Offset within the page |
| req_wdata_i | input | 32 | Store data |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_data_o | output | 32 | Load data |
| rsp_err_o | output | 1 | Access matched no operation |
| sw_err_o | output | 1 | Pulled ring was already invalid |
| irq_raise_i | input | 3 | Per-ring raise pulse for rings 3..1 |
| irq_o | output | 3 | External interrupt lines for rings 3..1 |
| save_valid_o | output | 1 | Save request valid |
| save_ready_i | input | 1 | Save request accepted |
| save_ring_o | output | 2 | Ring being saved |
| save_blk_o | output | 4 | VP block of the saved context |
| save_idx_o | output | 24 | VP index of the saved context |

## Verification
An interrupt raise and a pull's line drop can land on the same ring in the same clock. The bench provokes this by pulsing irq_raise_i for rings 1 and 2 in the very cycle an OS pull is accepted. It then expects ring 1's line low (the pull wins) and ring 2's line high (outside the pull's reach). A second overlap comes from a hardware-owned pull: the bench holds save_ready_i low for several cycles while raising nothing. It checks that the lines and CAM words stay untouched until the acceptance cycle, and that they change all at once after it.

// File: rtl/ctxpull_pkg.sv
package ctxpull_pkg;
  localparam int NRINGS      = 4;
  localparam int RING_W      = $clog2(NRINGS);
  localparam int CAM_W       = 32;
  localparam int VALID_BIT   = CAM_W - 1;
  localparam int HW_BIT      = CAM_W - 2;
  localparam int BLK_W       = 4;
  localparam int IDX_W       = 24;
  localparam int ADDR_W      = 12;
  localparam int PAGE_W      = 2;
  localparam int RING_STRIDE = 16;
  localparam int CAM_OFS     = 8;
  localparam int STRIDE_SH   = $clog2(RING_STRIDE);

  localparam logic [ADDR_W-1:0] OFS_PULL_OS_LD   = 12'h818;
  localparam logic [ADDR_W-1:0] OFS_PULL_OS_ST   = 12'hC18;
  localparam logic [ADDR_W-1:0] OFS_PULL_PHYS_ST = 12'hC38;

  localparam logic [PAGE_W-1:0] PG_USER = 2'd0;
  localparam logic [PAGE_W-1:0] PG_HV   = 2'd3;

  localparam logic [RING_W-1:0] RING_OS   = 2'd1;
  localparam logic [RING_W-1:0] RING_PHYS = 2'd3;

  typedef enum logic [1:0] {OP_NONE, OP_RD_CAM, OP_WR_CAM, OP_PULL} op_e;
  typedef enum logic {ST_IDLE, ST_SAVE} state_e;

  function automatic logic cam_valid(input logic [CAM_W-1:0] w);
    return w[VALID_BIT];
  endfunction

  function automatic logic cam_hw(input logic [CAM_W-1:0] w);
    return w[HW_BIT];
  endfunction

  function automatic logic [BLK_W-1:0] cam_blk(input logic [CAM_W-1:0] w);
    return w[IDX_W +: BLK_W];
  endfunction

  function automatic logic [IDX_W-1:0] cam_idx(input logic [CAM_W-1:0] w);
    return w[IDX_W-1:0];
  endfunction

  // rings 0..top are touched by a pull of ring top
  function automatic logic [NRINGS-1:0] reach_mask(input logic [RING_W-1:0] top);
    logic [NRINGS-1:0] m;
    for (int i = 0; i < NRINGS; i++) m[i] = (i <= int'(top));
    return m;
  endfunction
endpackage

// File: rtl/ctxpull_decode.sv
module ctxpull_decode
  import ctxpull_pkg::*;
(
  input  logic              we_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o,
  output logic [RING_W-1:0] ring_o,
  output logic              load_o
);
  localparam logic [ADDR_W-1:0] CAM_SPAN = ADDR_W'(NRINGS * RING_STRIDE);

  logic cam_hit;
  assign cam_hit = (page_i == PG_HV) && (addr_i < CAM_SPAN) &&
                   (addr_i[STRIDE_SH-1:0] == STRIDE_SH'(CAM_OFS));
  assign load_o  = !we_i;

  always_comb begin
    op_o   = OP_NONE;
    ring_o = '0;
    if (cam_hit) begin
      op_o   = we_i ? OP_WR_CAM : OP_RD_CAM;
      ring_o = addr_i[STRIDE_SH +: RING_W];
    end else if (!we_i && addr_i == OFS_PULL_OS_LD && page_i != PG_USER) begin
      op_o   = OP_PULL;
      ring_o = RING_OS;
    end else if (we_i && addr_i == OFS_PULL_OS_ST && page_i != PG_USER) begin
      op_o   = OP_PULL;
      ring_o = RING_OS;
    end else if (we_i && addr_i == OFS_PULL_PHYS_ST && page_i == PG_HV) begin
      op_o   = OP_PULL;
      ring_o = RING_PHYS;
    end
  end
endmodule

// File: rtl/ctxpull_ring_bank.sv
module ctxpull_ring_bank
  import ctxpull_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [RING_W-1:0]             wr_ring_i,
  input  logic [CAM_W-1:0]              wr_data_i,
  input  logic                          inv_en_i,
  input  logic [RING_W-1:0]             inv_ring_i,
  input  logic [NRINGS-1:1]             irq_raise_i,
  output logic [NRINGS-1:0][CAM_W-1:0]  cam_o,
  output logic [NRINGS-1:1]             irq_o
);
  logic [NRINGS-1:0] kill;
  assign kill = inv_en_i ? reach_mask(inv_ring_i) : '0;

  for (genvar r = 0; r < NRINGS; r++) begin : g_cam
    logic wr_here;
    assign wr_here = wr_en_i && (wr_ring_i == RING_W'(r));

    always_ff @(posedge clk) begin
      if (!rst_n)          cam_o[r] <= '0;
      else if (wr_here)    cam_o[r] <= wr_data_i;
      else if (kill[r])    cam_o[r][VALID_BIT] <= 1'b0;
    end

    // R3
    inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_en_i && (inv_ring_i >= RING_W'(r)) |=> !cam_valid(cam_o[r]));
    // R3
    inv_keeps_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_en_i && !wr_here |=> cam_o[r][VALID_BIT-1:0] == $past(cam_o[r][VALID_BIT-1:0]));
  end

  for (genvar r = 1; r < NRINGS; r++) begin : g_irq
    always_ff @(posedge clk) begin
      if (!rst_n)              irq_o[r] <= 1'b0;
      else if (kill[r])        irq_o[r] <= 1'b0;
      else if (irq_raise_i[r]) irq_o[r] <= 1'b1;
    end

    // R4
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_en_i && (inv_ring_i >= RING_W'(r)) |=> !irq_o[r]);
    // R11
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_raise_i[r] && !(inv_en_i && inv_ring_i >= RING_W'(r)) |=> irq_o[r]);
  end
endmodule

// File: rtl/ctxpull_seq.sv
module ctxpull_seq
  import ctxpull_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_save_en_i,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  op_e                           op_i,
  input  logic [RING_W-1:0]             ring_i,
  input  logic                          load_i,
  input  logic [NRINGS-1:0][CAM_W-1:0]  cam_i,
  output logic                          wr_en_o,
  output logic                          inv_en_o,
  output logic [RING_W-1:0]             inv_ring_o,
  output logic                          rsp_valid_o,
  output logic [CAM_W-1:0]              rsp_data_o,
  output logic                          rsp_err_o,
  output logic                          sw_err_o,
  output logic                          save_valid_o,
  input  logic                          save_ready_i,
  output logic [RING_W-1:0]             save_ring_o,
  output logic [BLK_W-1:0]              save_blk_o,
  output logic [IDX_W-1:0]              save_idx_o
);
  state_e            state_q;
  logic [RING_W-1:0] hold_ring;
  logic [CAM_W-1:0]  hold_word;
  logic              hold_load;

  logic [CAM_W-1:0] cur_word;
  logic fire, is_pull, need_save, pull_now, save_done, finish_pull;
  logic [CAM_W-1:0] fin_word;

  assign req_ready_o = (state_q == ST_IDLE);
  assign fire        = req_valid_i && req_ready_o;
  assign cur_word    = cam_i[ring_i];
  assign is_pull     = fire && (op_i == OP_PULL);
  assign need_save   = cfg_save_en_i && cam_hw(cur_word);
  assign pull_now    = is_pull && !need_save;
  assign save_done   = save_valid_o && save_ready_i;
  assign finish_pull = pull_now || save_done;
  assign fin_word    = save_done ? hold_word : cur_word;

  assign wr_en_o     = fire && (op_i == OP_WR_CAM);
  assign inv_en_o    = finish_pull;
  assign inv_ring_o  = save_done ? hold_ring : ring_i;

  assign save_valid_o = (state_q == ST_SAVE);
  assign save_ring_o  = hold_ring;
  assign save_blk_o   = cam_blk(hold_word);
  assign save_idx_o   = cam_idx(hold_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      hold_ring <= '0;
      hold_word <= '0;
      hold_load <= 1'b0;
    end else if (is_pull && need_save) begin
      state_q   <= ST_SAVE;
      hold_ring <= ring_i;
      hold_word <= cur_word;
      hold_load <= load_i;
    end else if (save_done) begin
      state_q   <= ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      rsp_err_o   <= 1'b0;
      sw_err_o    <= 1'b0;
    end else begin
      rsp_valid_o <= (fire && !(is_pull && need_save)) || save_done;
      rsp_err_o   <= fire && (op_i == OP_NONE);
      sw_err_o    <= finish_pull && !cam_valid(fin_word);
      if (save_done)
        rsp_data_o <= hold_load ? hold_word : '0;
      else if (fire && (op_i == OP_RD_CAM || (op_i == OP_PULL && load_i)))
        rsp_data_o <= cur_word;
      else
        rsp_data_o <= '0;
    end
  end

  // R5
  save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_valid_o && !save_ready_i |=> save_valid_o && $stable(save_ring_o) &&
                                      $stable(save_blk_o) && $stable(save_idx_o));
  // R6
  save_blocks_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_valid_o && !save_ready_i |-> !inv_en_o);
  // R10
  rsp_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(fire || save_done));
  // R7
  sw_err_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_err_o |-> rsp_valid_o);
  // R9
  err_no_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err_o |-> $past(!inv_en_o && !wr_en_o) && rsp_data_o == '0);
endmodule

// File: rtl/ctxpull_unit.sv
module ctxpull_unit
  import ctxpull_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_save_en_i,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_we_i,
  input  logic [PAGE_W-1:0]    req_page_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [CAM_W-1:0]     req_wdata_i,
  output logic                 rsp_valid_o,
  output logic [CAM_W-1:0]     rsp_data_o,
  output logic                 rsp_err_o,
  output logic                 sw_err_o,
  input  logic [NRINGS-1:1]    irq_raise_i,
  output logic [NRINGS-1:1]    irq_o,
  output logic                 save_valid_o,
  input  logic                 save_ready_i,
  output logic [RING_W-1:0]    save_ring_o,
  output logic [BLK_W-1:0]     save_blk_o,
  output logic [IDX_W-1:0]     save_idx_o
);
  op_e                          dec_op;
  logic [RING_W-1:0]            dec_ring;
  logic                         dec_load;
  logic [NRINGS-1:0][CAM_W-1:0] cam_words;
  logic                         wr_en;
  logic                         inv_en;
  logic [RING_W-1:0]            inv_ring;

  ctxpull_decode u_dec (
    .we_i   (req_we_i),
    .page_i (req_page_i),
    .addr_i (req_addr_i),
    .op_o   (dec_op),
    .ring_o (dec_ring),
    .load_o (dec_load)
  );

  ctxpull_ring_bank u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .wr_ring_i   (dec_ring),
    .wr_data_i   (req_wdata_i),
    .inv_en_i    (inv_en),
    .inv_ring_i  (inv_ring),
    .irq_raise_i (irq_raise_i),
    .cam_o       (cam_words),
    .irq_o       (irq_o)
  );

  ctxpull_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_save_en_i (cfg_save_en_i),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .op_i          (dec_op),
    .ring_i        (dec_ring),
    .load_i        (dec_load),
    .cam_i         (cam_words),
    .wr_en_o       (wr_en),
    .inv_en_o      (inv_en),
    .inv_ring_o    (inv_ring),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_data_o    (rsp_data_o),
    .rsp_err_o     (rsp_err_o),
    .sw_err_o      (sw_err_o),
    .save_valid_o  (save_valid_o),
    .save_ready_i  (save_ready_i),
    .save_ring_o   (save_ring_o),
    .save_blk_o    (save_blk_o),
    .save_idx_o    (save_idx_o)
  );

  // R6
  save_stalls_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_valid_o && !save_ready_i |=> !rsp_valid_o);
endmodule

// File: tb/ctxpull_unit_test.sv
module ctxpull_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VMASK = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_save_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [1:0]  req_page = '0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_err;
  logic        sw_err;
  logic [3:1]  irq_raise = '0;
  logic [3:1]  irq;
  logic        save_valid;
  logic        save_ready = 1'b0;
  logic [1:0]  save_ring;
  logic [3:0]  save_blk;
  logic [23:0] save_idx;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctxpull_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_save_en_i(cfg_save_en),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_page_i(req_page), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_err_o(rsp_err),
    .sw_err_o(sw_err), .irq_raise_i(irq_raise), .irq_o(irq),
    .save_valid_o(save_valid), .save_ready_i(save_ready), .save_ring_o(save_ring),
    .save_blk_o(save_blk), .save_idx_o(save_idx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic v, input logic hw,
                                     input logic [3:0] blk, input logic [23:0] idx);
    return {v, hw, 2'b00, blk, idx};
  endfunction

  // one access; on return the response of a no-save access is visible
  task automatic issue(input logic we, input logic [1:0] page, input logic [11:0] addr,
                       input logic [31:0] data, input logic [3:1] raise);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_page = page; req_addr = addr;
    req_wdata = data; irq_raise = raise;
    @(negedge clk);
    req_valid = 1'b0; irq_raise = '0;
  endtask

  task automatic wr_cam(input int r, input logic [31:0] w);
    issue(1'b1, 2'd3, 12'(r*16 + 8), w, '0);
  endtask

  task automatic rd_cam(input int r, output logic [31:0] w);
    issue(1'b0, 2'd3, 12'(r*16 + 8), '0, '0);
    w = rsp_data;
  endtask

  task automatic raise_all();
    @(negedge clk); irq_raise = 3'b111;
    @(negedge clk); irq_raise = '0;
  endtask

  task automatic t_reset();
    logic [31:0] w;
    check("R10 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R6 reset ready", {31'd0, req_ready}, 32'd1);
    check("R4 reset irq", {29'd0, irq}, 32'd0);
    check("R5 reset save_valid", {31'd0, save_valid}, 32'd0);
    for (int r = 0; r < 4; r++) begin
      rd_cam(r, w);
      check("R1 reset cam word", w, 32'd0);
    end
  endtask

  task automatic t_cam_access();
    logic [31:0] w;
    for (int r = 0; r < 4; r++) wr_cam(r, mk(1'b1, 1'b0, 4'(r+1), 24'h10 * 24'(r+1)));
    for (int r = 0; r < 4; r++) begin
      rd_cam(r, w);
      check("R1 cam readback", w, mk(1'b1, 1'b0, 4'(r+1), 24'h10 * 24'(r+1)));
      check("R10 read rsp_valid", {31'd0, rsp_valid}, 32'd1);
    end
  endtask

  task automatic t_os_load_pull();
    logic [31:0] w;
    cfg_save_en = 1'b0;
    raise_all();
    issue(1'b0, 2'd1, 12'h818, '0, '0);
    check("R2 pull returns old word", rsp_data, mk(1'b1, 1'b0, 4'd2, 24'h20));
    check("R10 pull rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check("R4 R10 irq dropped with rsp", {29'd0, irq}, 32'b110);
    check("R7 no sw_err on valid pull", {31'd0, sw_err}, 32'd0);
    rd_cam(0, w); check("R3 ring0 cleared", w, mk(1'b1, 1'b0, 4'd1, 24'h10) & ~VMASK);
    rd_cam(1, w); check("R3 ring1 cleared", w, mk(1'b1, 1'b0, 4'd2, 24'h20) & ~VMASK);
    rd_cam(2, w); check("R3 ring2 untouched", w, mk(1'b1, 1'b0, 4'd3, 24'h30));
    rd_cam(3, w); check("R3 ring3 untouched", w, mk(1'b1, 1'b0, 4'd4, 24'h40));
  endtask

  task automatic t_phys_store_pull();
    logic [31:0] w;
    raise_all();
    issue(1'b1, 2'd3, 12'hC38, 32'hDEAD_BEEF, '0);
    check("R8 store pull data zero", rsp_data, 32'd0);
    check("R8 store pull rsp", {31'd0, rsp_valid}, 32'd1);
    check("R4 all irq low", {29'd0, irq}, 32'd0);
    rd_cam(2, w); check("R3 ring2 cleared", w, mk(1'b1, 1'b0, 4'd3, 24'h30) & ~VMASK);
    rd_cam(3, w); check("R3 ring3 cleared", w, mk(1'b1, 1'b0, 4'd4, 24'h40) & ~VMASK);
  endtask

  task automatic t_save_path();
    logic [31:0] w;
    wr_cam(3, mk(1'b1, 1'b1, 4'hA, 24'h123456));
    cfg_save_en = 1'b1;
    raise_all();
    issue(1'b1, 2'd3, 12'hC38, '0, '0);
    check("R5 save_valid", {31'd0, save_valid}, 32'd1);
    check("R5 save ring", {30'd0, save_ring}, 32'd3);
    check("R5 save blk", {28'd0, save_blk}, 32'hA);
    check("R5 save idx", {8'd0, save_idx}, 32'h123456);
    check("R6 ready low", {31'd0, req_ready}, 32'd0);
    check("R6 no rsp yet", {31'd0, rsp_valid}, 32'd0);
    check("R6 irq held", {29'd0, irq}, 32'b111);
    repeat (3) @(negedge clk);
    check("R5 still valid", {31'd0, save_valid}, 32'd1);
    check("R5 idx stable", {8'd0, save_idx}, 32'h123456);
    check("R6 irq still held", {29'd0, irq}, 32'b111);
    save_ready = 1'b1;
    @(negedge clk);
    save_ready = 1'b0;
    check("R6 rsp after accept", {31'd0, rsp_valid}, 32'd1);
    check("R6 irq dropped after accept", {29'd0, irq}, 32'd0);
    check("R5 save done", {31'd0, save_valid}, 32'd0);
    check("R6 ready back", {31'd0, req_ready}, 32'd1);
    rd_cam(3, w); check("R6 ring3 cleared after save", w, mk(1'b0, 1'b1, 4'hA, 24'h123456));
  endtask

  task automatic t_no_save_cases();
    wr_cam(1, mk(1'b1, 1'b1, 4'h3, 24'h333));
    cfg_save_en = 1'b0;
    issue(1'b0, 2'd1, 12'h818, '0, '0);
    check("R5 cfg off no save", {31'd0, save_valid}, 32'd0);
    check("R2 cfg off rsp word", rsp_data, mk(1'b1, 1'b1, 4'h3, 24'h333));
    wr_cam(1, mk(1'b1, 1'b0, 4'h4, 24'h444));
    cfg_save_en = 1'b1;
    issue(1'b0, 2'd2, 12'h818, '0, '0);
    check("R5 sw-owned no save", {31'd0, save_valid}, 32'd0);
    check("R2 pool-page pull rsp", rsp_data, mk(1'b1, 1'b0, 4'h4, 24'h444));
    cfg_save_en = 1'b0;
  endtask

  task automatic t_invalid_pull();
    logic [31:0] w;
    wr_cam(0, mk(1'b1, 1'b0, 4'h5, 24'h500));
    wr_cam(1, mk(1'b0, 1'b0, 4'h5, 24'h55));
    issue(1'b1, 2'd1, 12'hC18, '0, '0);
    check("R7 sw_err pulse", {31'd0, sw_err}, 32'd1);
    check("R8 OS store pull rsp", {31'd0, rsp_valid}, 32'd1);
    @(negedge clk);
    check("R7 sw_err one cycle", {31'd0, sw_err}, 32'd0);
    rd_cam(0, w); check("R7 lower ring still cleared", w, mk(1'b0, 1'b0, 4'h5, 24'h500));
  endtask

  task automatic t_unmatched();
    logic [31:0] w;
    wr_cam(3, mk(1'b1, 1'b0, 4'h7, 24'h777));
    wr_cam(0, mk(1'b1, 1'b0, 4'h6, 24'h666));
    raise_all();
    issue(1'b1, 2'd1, 12'hC38, '0, '0);
    check("R9 err pulse", {31'd0, rsp_err}, 32'd1);
    check("R9 data zero", rsp_data, 32'd0);
    check("R9 irq unchanged", {29'd0, irq}, 32'b111);
    issue(1'b1, 2'd1, 12'h008, 32'h1234_5678, '0);
    check("R9 OS-page cam store err", {31'd0, rsp_err}, 32'd1);
    issue(1'b0, 2'd3, 12'h900, '0, '0);
    check("R9 unknown load err", {31'd0, rsp_err}, 32'd1);
    rd_cam(3, w); check("R9 ring3 unchanged", w, mk(1'b1, 1'b0, 4'h7, 24'h777));
    rd_cam(0, w); check("R9 ring0 unchanged", w, mk(1'b1, 1'b0, 4'h6, 24'h666));
    check("R9 no err on match", {31'd0, rsp_err}, 32'd0);
  endtask

  task automatic t_raise_vs_pull();
    issue(1'b1, 2'd3, 12'hC38, '0, '0);
    check("R4 lines low before", {29'd0, irq}, 32'd0);
    wr_cam(1, mk(1'b1, 1'b0, 4'h8, 24'h888));
    issue(1'b0, 2'd1, 12'h818, '0, 3'b011);
    check("R11 pull beats raise", {29'd0, irq}, 32'b010);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cam_access();
    t_os_load_pull();
    t_phys_store_pull();
    t_save_path();
    t_no_save_cases();
    t_invalid_pull();
    t_unmatched();
    t_raise_vs_pull();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule